// File: doc/BRIEF.md
# Frame-Referenced NCO Clock Recovery Loop

This block rebuilds a receive PCM bit clock from a free-running high-frequency clock. The two clocks need no fixed frequency or phase relation. It measures the phase by counting general-clock ticks. The general clock is the high-frequency clock divided by four. Counting starts at the line-side 6 ms multiframe marker and stops at the PCM-side multiframe marker. The measured count, minus a programmed phase target and shifted right by a programmable gain, is added into an integrator. In closed-loop mode the integrator is added to the programmed nominal frequency word. In open-loop mode the nominal word is used alone.

The resulting frequency word drives an accumulator-based NCO. At the end of each divider cycle the NCO adds the word to its residue. The carry out of the fraction (0 to 3) selects the length of the next divider cycle: N-1, N, N+1 or N+2 high-frequency cycles. The divider emits a one-cycle pulse at each cycle end, and a toggle stage halves that pulse train to form the receive clock. A dedicated loop reset puts the counter, the integrator and the accumulator back to their start values without a full chip reset.

The detector is a two-state machine. Its states are PD_IDLE and PD_RUN, with these transitions:
- start: PD_IDLE to PD_RUN on a line marker.
- restart: PD_RUN to PD_RUN on a line marker.
- stop: PD_RUN to PD_IDLE on a PCM marker.
- saturate: PD_RUN to PD_IDLE when the count reaches the limit.

The divider is a three-state machine. Its states are DV_IDLE, DV_COUNT and DV_LAST, with these transitions:
- first load: DV_IDLE to DV_COUNT.
- last cycle: DV_COUNT to DV_LAST when the down-counter is 1.
- reload: DV_LAST to DV_COUNT.

Top module: `frame_nco_dpll`

## Requirements
- R1: After reset the outputs take these values: `rclk` is 0, `div_clk` is 0, `meas_count` is 0 and `sat_err` is 0. `freq_word` equals `factor`, limited to at most 3·2^FRAC_W.
- R2: A line marker sampled at edge e0 followed by a PCM marker sampled at edge e0+K sets `meas_count` to floor((K-1)/4). A PCM marker with no measurement running leaves `meas_count` unchanged.
- R3: If the count reaches `mf_limit` before a PCM marker arrives, the measurement ends. `sat_err` goes to 1 and `meas_count` keeps its old value. The next completed measurement clears `sat_err`.
- R4: In closed loop, each completed measurement adds (meas_count − phase_target) arithmetically shifted right by `gain` to a signed integrator. `freq_word` is then factor + integrator, limited to the range 0 to 3·2^FRAC_W.
- R5: In open loop, `freq_word` is the limited `factor` alone. Measurements leave the integrator unchanged, which shows once closed loop is selected again.
- R6: The NCO starts with a residue of 0. At each divider reload, s = residue + freq_word, the next divisor is DIV_NOM−1+floor(s/2^FRAC_W), and the new residue is s mod 2^FRAC_W.
- R7: `div_clk` is a single-cycle pulse. The gap from one pulse to the next equals the divisor chosen at the earlier pulse, so the divisor changes only at a cycle boundary.
- R8: `rclk` toggles after every `div_clk` pulse and at no other time, so it runs at half the pulse rate.
- R9: `dpll_rst` returns the loop to its start state: integrator 0, residue 0, detector idle, `meas_count` 0, `sat_err` 0, `rclk` 0.
- R10: A line marker during a running measurement restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hf_clk | input | 1 | Free-running high-frequency clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dpll_rst | input | 1 | Loop re-initialise, active high |
| closed_loop | input | 1 | 1 = add integrator to the frequency word |
| line_mf | input | 1 | Line-side multiframe marker (start) |
| pcm_mf | input | 1 | PCM-side multiframe marker (stop) |
| mf_limit | input | CNT_W | Saturation limit of the phase count |
| phase_target | input | CNT_W | Count that gives zero phase error |
| gain | input | GAIN_W | Right-shift applied to the phase error |
| factor | input | FRAC_W+2 | Nominal frequency word |
| rclk | output | 1 | Recovered receive clock |
| div_clk | output | 1 | Divider cycle-end pulse |
| meas_count | output | CNT_W | Last completed phase count |
| sat_err | output | 1 | Last measurement saturated |
| freq_word | output | FRAC_W+2 | Word currently driving the NCO |

## Verification
The measured count appears in `meas_count` one edge after the PCM marker is sampled. The integrator updates one edge later, and `freq_word` follows it with no added delay. The bench therefore reads both three falling edges after the stop marker. Saturation is flagged one edge after the count reaches the limit, and the bench waits well past that point before it reads the flag. For the divider, the bench logs the falling edge at which each `div_clk` pulse is seen. It compares each gap between pulses with a divisor sequence worked out from R6. It reads `rclk` one falling edge after each pulse.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    typedef enum logic {
        PD_IDLE,
        PD_RUN
    } pd_state_t;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_COUNT,
        DV_LAST
    } dv_state_t;
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
    import dpll_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dpll_rst,
    input  logic             line_mf,
    input  logic             pcm_mf,
    input  logic [CNT_W-1:0] mf_limit,
    output logic [CNT_W-1:0] meas_count,
    output logic             meas_strobe,
    output logic             sat_err
);
    pd_state_t        st_q, st_d;
    logic [1:0]       presc_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PD_IDLE: if (line_mf) st_d = PD_RUN;
            PD_RUN: begin
                if (line_mf)               st_d = PD_RUN;
                else if (pcm_mf)           st_d = PD_IDLE;
                else if (cnt_q >= mf_limit) st_d = PD_IDLE;
            end
            default: st_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dpll_rst) st_q <= PD_IDLE;
        else                    st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dpll_rst) begin
            presc_q     <= '0;
            cnt_q       <= '0;
            meas_count  <= '0;
            meas_strobe <= 1'b0;
            sat_err     <= 1'b0;
        end else begin
            meas_strobe <= 1'b0;
            unique case (st_q)
                PD_IDLE: begin
                    if (line_mf) begin
                        presc_q <= '0;
                        cnt_q   <= '0;
                    end
                end
                PD_RUN: begin
                    if (line_mf) begin
                        presc_q <= '0;
                        cnt_q   <= '0;
                    end else if (pcm_mf) begin
                        meas_count  <= cnt_q;
                        meas_strobe <= 1'b1;
                        sat_err     <= 1'b0;
                    end else if (cnt_q >= mf_limit) begin
                        sat_err <= 1'b1;
                    end else begin
                        presc_q <= presc_q + 2'd1;
                        if (presc_q == 2'd3) cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_sat_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_err) |-> $past(st_q == PD_RUN));

    assert_limit_ends_R3: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        (st_q == PD_RUN && cnt_q >= mf_limit && !line_mf && !pcm_mf)
        |=> (st_q == PD_IDLE && sat_err));

    assert_meas_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas_count) |-> ($past(st_q == PD_RUN && pcm_mf && !line_mf) || $past(dpll_rst)));
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 12,
    parameter int GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpll_rst,
    input  logic              meas_strobe,
    input  logic [CNT_W-1:0]  meas_count,
    input  logic [CNT_W-1:0]  phase_target,
    input  logic [GAIN_W-1:0] gain,
    input  logic              closed_loop,
    input  logic [FRAC_W+1:0] factor,
    output logic [FRAC_W+1:0] freq_word
);
    localparam int W_W   = FRAC_W + 2;
    localparam int INT_W = CNT_W + 4;
    localparam int SUM_W = INT_W + 2;
    localparam logic signed [SUM_W-1:0] RAW_MAX = SUM_W'(3) <<< FRAC_W;

    logic signed [INT_W-1:0] integ_q;
    logic signed [CNT_W:0]   err_s;
    logic signed [INT_W-1:0] step_s;
    logic signed [SUM_W-1:0] raw_s;

    always_comb begin
        err_s  = $signed({1'b0, meas_count}) - $signed({1'b0, phase_target});
        step_s = INT_W'(err_s >>> gain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dpll_rst)            integ_q <= '0;
        else if (meas_strobe && closed_loop) integ_q <= integ_q + step_s;
    end

    always_comb begin
        raw_s = SUM_W'($signed({1'b0, factor}));
        if (closed_loop) raw_s = raw_s + SUM_W'(integ_q);
        if (raw_s < 0)            freq_word = '0;
        else if (raw_s > RAW_MAX) freq_word = RAW_MAX[W_W-1:0];
        else                      freq_word = raw_s[W_W-1:0];
    end

    assert_integ_hold_open_R5: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        !closed_loop |=> $stable(integ_q));

    assert_integ_only_on_meas_R4: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        !meas_strobe |=> $stable(integ_q));
endmodule

// File: rtl/dpll_nco_div.sv
module dpll_nco_div
    import dpll_pkg::*;
#(
    parameter int FRAC_W  = 12,
    parameter int DIV_NOM = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpll_rst,
    input  logic [FRAC_W+1:0] freq_word,
    output logic              div_clk,
    output logic              rclk
);
    localparam int W_W   = FRAC_W + 2;
    localparam int DIV_W = $clog2(DIV_NOM + 3);

    dv_state_t         st_q, st_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [W_W-1:0]    sum_w;
    logic [DIV_W-1:0]  next_div;

    always_comb begin
        sum_w    = W_W'(acc_q) + freq_word;
        next_div = DIV_W'(DIV_NOM - 1) + DIV_W'(sum_w[W_W-1:FRAC_W]);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE:  st_d = DV_COUNT;
            DV_COUNT: if (cnt_q == DIV_W'(1)) st_d = DV_LAST;
            DV_LAST:  st_d = DV_COUNT;
            default:  st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dpll_rst) st_q <= DV_IDLE;
        else                    st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dpll_rst) begin
            cnt_q <= '0;
            acc_q <= '0;
            rclk  <= 1'b0;
        end else begin
            unique case (st_q)
                DV_IDLE, DV_LAST: begin
                    cnt_q <= next_div - 1'b1;
                    acc_q <= sum_w[FRAC_W-1:0];
                    if (st_q == DV_LAST) rclk <= ~rclk;
                end
                DV_COUNT: cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb div_clk = (st_q == DV_LAST);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        div_clk |=> !div_clk);

    assert_rclk_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        div_clk |=> (rclk != $past(rclk)));

    assert_rclk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        !div_clk |=> $stable(rclk));

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n || dpll_rst)
        (st_q == DV_COUNT) |-> (cnt_q >= DIV_W'(1) && cnt_q <= DIV_W'(DIV_NOM + 1)));
endmodule

// File: rtl/frame_nco_dpll.sv
module frame_nco_dpll #(
    parameter int CNT_W   = 16,
    parameter int FRAC_W  = 12,
    parameter int GAIN_W  = 4,
    parameter int DIV_NOM = 5
) (
    input  logic              hf_clk,
    input  logic              rst_n,
    input  logic              dpll_rst,
    input  logic              closed_loop,
    input  logic              line_mf,
    input  logic              pcm_mf,
    input  logic [CNT_W-1:0]  mf_limit,
    input  logic [CNT_W-1:0]  phase_target,
    input  logic [GAIN_W-1:0] gain,
    input  logic [FRAC_W+1:0] factor,
    output logic              rclk,
    output logic              div_clk,
    output logic [CNT_W-1:0]  meas_count,
    output logic              sat_err,
    output logic [FRAC_W+1:0] freq_word
);
    logic meas_strobe;

    dpll_phase_det #(.CNT_W(CNT_W)) u_pd (
        .clk        (hf_clk),
        .rst_n      (rst_n),
        .dpll_rst   (dpll_rst),
        .line_mf    (line_mf),
        .pcm_mf     (pcm_mf),
        .mf_limit   (mf_limit),
        .meas_count (meas_count),
        .meas_strobe(meas_strobe),
        .sat_err    (sat_err)
    );

    dpll_loop_filter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W)) u_lf (
        .clk         (hf_clk),
        .rst_n       (rst_n),
        .dpll_rst    (dpll_rst),
        .meas_strobe (meas_strobe),
        .meas_count  (meas_count),
        .phase_target(phase_target),
        .gain        (gain),
        .closed_loop (closed_loop),
        .factor      (factor),
        .freq_word   (freq_word)
    );

    dpll_nco_div #(.FRAC_W(FRAC_W), .DIV_NOM(DIV_NOM)) u_nco (
        .clk      (hf_clk),
        .rst_n    (rst_n),
        .dpll_rst (dpll_rst),
        .freq_word(freq_word),
        .div_clk  (div_clk),
        .rclk     (rclk)
    );
endmodule

// File: tb/frame_nco_dpll_tb_top.sv
`timescale 1ns/1ps
module frame_nco_dpll_tb_top;
    localparam int CNT_W = 16, FRAC_W = 12, GAIN_W = 4, DIV_NOM = 5;
    localparam int WMAX = 3 << FRAC_W;

    logic hf_clk = 1'b0;
    logic rst_n = 1'b0, dpll_rst = 1'b0, closed_loop = 1'b0;
    logic line_mf = 1'b0, pcm_mf = 1'b0;
    logic [CNT_W-1:0] mf_limit = 16'd1000, phase_target = 16'd20;
    logic [GAIN_W-1:0] gain = 4'd2;
    logic [FRAC_W+1:0] factor = 14'd6144;
    logic rclk, div_clk, sat_err;
    logic [CNT_W-1:0] meas_count;
    logic [FRAC_W+1:0] freq_word;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #10 hf_clk = ~hf_clk;

    frame_nco_dpll #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .DIV_NOM(DIV_NOM)) dut_i (
        .hf_clk(hf_clk), .rst_n(rst_n), .dpll_rst(dpll_rst), .closed_loop(closed_loop),
        .line_mf(line_mf), .pcm_mf(pcm_mf), .mf_limit(mf_limit), .phase_target(phase_target),
        .gain(gain), .factor(factor), .rclk(rclk), .div_clk(div_clk),
        .meas_count(meas_count), .sat_err(sat_err), .freq_word(freq_word)
    );

    always @(posedge hf_clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_count(input int k);
        return (k - 1) / 4;
    endfunction

    function automatic int ref_word(input int f, input int integ, input bit cl);
        int raw = cl ? f + integ : f;
        if (raw < 0) return 0;
        if (raw > WMAX) return WMAX;
        return raw;
    endfunction

    function automatic int ref_step(input int cnt, input int tgt, input int g);
        return (cnt - tgt) >>> g;
    endfunction

    task automatic measure(input int k);
        @(negedge hf_clk) line_mf = 1'b1;
        @(negedge hf_clk) line_mf = 1'b0;
        repeat (k - 1) @(negedge hf_clk);
        pcm_mf = 1'b1;
        @(negedge hf_clk) pcm_mf = 1'b0;
        repeat (2) @(negedge hf_clk);
    endtask

    task automatic loop_reset();
        @(negedge hf_clk) dpll_rst = 1'b1;
        @(negedge hf_clk) dpll_rst = 1'b0;
    endtask

    task automatic nco_check(input int w);
        int acc = 0, s = 0, prev = -1, j = 0, t = 0;
        int divs[0:17];
        for (int i = 0; i < 18; i++) begin
            s = acc + w;
            divs[i] = DIV_NOM - 1 + s / (1 << FRAC_W);
            acc = s % (1 << FRAC_W);
        end
        factor = 14'(w);
        loop_reset();
        while (j < 16 && t < 400) begin
            @(negedge hf_clk);
            t++;
            if (div_clk) begin
                if (prev >= 0) chk("R6/R7 divisor gap", t - prev, divs[j]);
                prev = t;
                @(negedge hf_clk);
                t++;
                chk("R8 rclk after pulse", int'(rclk), (j + 1) & 1);
                if (div_clk) chk("R7 pulse width", 1, 0);
                j++;
            end
        end
        chk("R7 pulse count", j, 16);
    endtask

    initial begin
        int k, integ, c, m0;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge hf_clk);
        rst_n = 1'b1;
        @(negedge hf_clk);
        chk("R1 rclk", int'(rclk), 0);
        chk("R1 div_clk", int'(div_clk), 0);
        chk("R1 meas_count", int'(meas_count), 0);
        chk("R1 sat_err", int'(sat_err), 0);
        chk("R1 freq_word", int'(freq_word), 6144);

        // R2 random spacings, open loop
        for (int i = 0; i < 10; i++) begin
            k = 2 + int'($urandom_range(0, 300));
            measure(k);
            chk("R2 count", int'(meas_count), ref_count(k));
        end
        measure(5);
        chk("R2 minimal spacing", int'(meas_count), 1);
        m0 = int'(meas_count);
        @(negedge hf_clk) pcm_mf = 1'b1;
        @(negedge hf_clk) pcm_mf = 1'b0;
        repeat (3) @(negedge hf_clk);
        chk("R2 idle stop ignored", int'(meas_count), m0);

        // R10 restart
        @(negedge hf_clk) line_mf = 1'b1;
        @(negedge hf_clk) line_mf = 1'b0;
        repeat (60) @(negedge hf_clk);
        measure(33);
        chk("R10 restart count", int'(meas_count), 8);

        // R3 saturation
        mf_limit = 16'd10;
        m0 = int'(meas_count);
        @(negedge hf_clk) line_mf = 1'b1;
        @(negedge hf_clk) line_mf = 1'b0;
        repeat (80) @(negedge hf_clk);
        chk("R3 sat flag", int'(sat_err), 1);
        chk("R3 count kept", int'(meas_count), m0);
        measure(9);
        chk("R3 cleared", int'(sat_err), 0);
        chk("R3 count after", int'(meas_count), 2);
        mf_limit = 16'd1000;

        // R4 closed loop
        closed_loop = 1'b1;
        integ = 0;
        measure(121);
        integ += ref_step(ref_count(121), 20, 2);
        chk("R4 positive step", int'(freq_word), ref_word(6144, integ, 1'b1));
        measure(41);
        integ += ref_step(ref_count(41), 20, 2);
        chk("R4 negative step", int'(freq_word), ref_word(6144, integ, 1'b1));
        for (int i = 0; i < 4; i++) begin
            k = 2 + int'($urandom_range(0, 200));
            gain = 4'($urandom_range(0, 5));
            measure(k);
            integ += ref_step(ref_count(k), 20, int'(gain));
            chk("R4 random step", int'(freq_word), ref_word(6144, integ, 1'b1));
        end

        // R5 open loop ignores measurement
        closed_loop = 1'b0;
        measure(250);
        chk("R5 open word", int'(freq_word), 6144);
        @(negedge hf_clk) closed_loop = 1'b1;
        @(negedge hf_clk);
        chk("R5 integrator held", int'(freq_word), ref_word(6144, integ, 1'b1));

        // R4 limits
        factor = 14'd0;
        gain = 4'd0;
        measure(5);
        integ += ref_step(1, 20, 0);
        chk("R4 floor", int'(freq_word), 0);
        factor = 14'd16383;
        @(negedge hf_clk);
        chk("R4 ceiling", int'(freq_word), ref_word(16383, integ, 1'b1));

        // R9 loop reset
        factor = 14'd6144;
        loop_reset();
        @(negedge hf_clk);
        chk("R9 integrator cleared", int'(freq_word), 6144);
        chk("R9 meas cleared", int'(meas_count), 0);
        chk("R9 rclk cleared", int'(rclk), 0);

        // R6 R7 R8 NCO sequence
        closed_loop = 1'b0;
        nco_check(0);
        nco_check(WMAX);
        nco_check(6144);
        for (int i = 0; i < 3; i++) begin
            c = int'($urandom_range(0, WMAX));
            nco_check(c);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule